// File: doc/BRIEF.md
# Command Sequencer Execution Engine

This engine runs a stored list of 32-bit instructions, one at a time and strictly in order. There is no branching, and it cannot read anything back from the hardware it controls. A write instruction produces a single-cycle, full-word strobe on a register-write bus that drives a peripheral register block. A timer instruction stalls the engine for a programmed number of cycles. After every write the engine inserts a programmable idle gap, so one write instruction does the work of a write followed by a wait. The gap is not added after timer instructions.

The host holds up to four sequence descriptors, each a start address and a length, and picks one with a select input. The engine runs that sequence once for each assertion of its enable. It reports completion with a one-cycle done pulse. A halt input freezes all progress, including the timer and the command counter. Dropping the enable aborts the run at once. The host can see a command counter, which it can clear.

Top module: `cmdseq_engine`

## Requirements
- R1: When the engine is idle with `run_en` high and `hold` low, and no run has yet been started during the current enable, `mem_rd_en` is high in the next cycle with `mem_rd_addr` equal to the selected base address, and `busy` is high.
- R2: Instructions are fetched from consecutive addresses base, base+1, and so on, up to base+len-1. Read data is taken one cycle after the fetch cycle.
- R3: An instruction with bit 31 = 1 is a write. Two cycles after its fetch cycle, `reg_wr_en` is high for exactly one cycle. In that cycle `reg_wr_addr` = {bits[30:24], 2'b00}, a word-aligned 9-bit address, and `reg_wr_data` = bits[23:0] zero-extended to 32 bits.
- R4: The next fetch after a write fetched in cycle F happens in cycle F+2+G, where G is `wr_gap`. With G = 0, fetches occur every two cycles.
- R5: An instruction with bit 31 = 0 is a timer with a cycle count N in bits[29:0]. Bit 30 is ignored. The next fetch happens in cycle F+2+max(N,1), and no write gap is added.
- R6: After the last instruction, `done` is high for one cycle, in the cycle where the next fetch would otherwise have happened. `busy` is low from that cycle on, and there is no further fetch while `run_en` stays high.
- R7: A selected length of 0 gives a `done` pulse in the cycle after the start, with no fetch.
- R8: While `hold` is high there is no fetch, no write strobe and no `done`, and the timer and `cmd_count` do not move. Every later event is delayed by exactly the number of held cycles.
- R9: Driving `run_en` low makes `busy` low in the next cycle, with no further fetch, write or `done`. A later enable restarts the run from the base address.
- R10: `cmd_count` increases by one for each instruction executed. A `cnt_clr` pulse makes it 0 in the next cycle.
- R11: `seq_sel` = k selects base `seq_base_all[k*MEM_AW +: MEM_AW]` and length `seq_len_all[k*LEN_W +: LEN_W]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | Enable; a run starts once per assertion, and deassertion aborts |
| hold | input | 1 | Freeze all progress |
| seq_sel | input | SEL_W | Selected sequence slot |
| seq_base_all | input | NUM_SEQ*MEM_AW | Packed start addresses |
| seq_len_all | input | NUM_SEQ*LEN_W | Packed lengths in instructions |
| wr_gap | input | GAP_W | Idle cycles inserted after each write |
| mem_rd_en | output | 1 | Command memory read strobe |
| mem_rd_addr | output | MEM_AW | Command memory address |
| mem_rd_data | input | 32 | Instruction word, one cycle after the read |
| reg_wr_en | output | 1 | Register write strobe |
| reg_wr_addr | output | 9 | Word-aligned register byte address |
| reg_wr_data | output | 32 | Register write data |
| cnt_clr | input | 1 | Clear the command counter |
| cmd_count | output | CNT_W | Instructions executed |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest situation to reach is a halt that starts inside an execute or wait interval and is then released, because every later fetch, strobe and done pulse must shift by exactly the held length. The stimulus first computes the whole fetch schedule of the random program. It then places the halt on a cycle strictly between two fetches and compares every cycle against the shifted schedule. An abort at a chosen mid-run cycle, followed by a fresh run, covers the restart path.

// File: rtl/cmdseq_pkg.sv
package cmdseq_pkg;
  localparam int INSTR_W = 32;
  localparam int TMR_W   = 30;
  localparam int REG_AW  = 9;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_EXEC  = 2'd2,
    ST_WAIT  = 2'd3
  } seq_state_t;

  function automatic logic instr_is_write(input logic [INSTR_W-1:0] w);
    return w[INSTR_W-1];
  endfunction

  // timer length, a zero count behaves as one cycle
  function automatic logic [TMR_W-1:0] instr_wait_len(input logic [INSTR_W-1:0] w);
    return (w[TMR_W-1:0] == '0) ? TMR_W'(1) : w[TMR_W-1:0];
  endfunction

  function automatic logic [REG_AW-1:0] instr_reg_addr(input logic [INSTR_W-1:0] w);
    return {w[30:24], 2'b00};
  endfunction

  function automatic logic [INSTR_W-1:0] instr_reg_data(input logic [INSTR_W-1:0] w);
    return {8'h00, w[23:0]};
  endfunction
endpackage

// File: rtl/cmdseq_slot_pick.sv
module cmdseq_slot_pick #(
  parameter int NUM_SEQ = 4,
  parameter int BASE_W  = 8,
  parameter int LEN_W   = 9,
  localparam int SEL_W  = (NUM_SEQ > 1) ? $clog2(NUM_SEQ) : 1
) (
  input  logic [SEL_W-1:0]          sel,
  input  logic [NUM_SEQ*BASE_W-1:0] base_all,
  input  logic [NUM_SEQ*LEN_W-1:0]  len_all,
  output logic [BASE_W-1:0]         base,
  output logic [LEN_W-1:0]          len
);
  logic [BASE_W-1:0] base_tab [NUM_SEQ];
  logic [LEN_W-1:0]  len_tab  [NUM_SEQ];

  for (genvar g = 0; g < NUM_SEQ; g++) begin : g_slot
    assign base_tab[g] = base_all[g*BASE_W +: BASE_W];
    assign len_tab[g]  = len_all[g*LEN_W +: LEN_W];
  end

  always_comb begin
    base = base_tab[0];
    len  = len_tab[0];
    for (int k = 0; k < NUM_SEQ; k++) begin
      if (sel == SEL_W'(k)) begin
        base = base_tab[k];
        len  = len_tab[k];
      end
    end
  end
endmodule

// File: rtl/cmdseq_timer.sv
module cmdseq_timer #(
  parameter int CW = 30
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          run,
  output logic          expire
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                     cnt <= '0;
    else if (load)               cnt <= load_val;
    else if (run && cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign expire = (cnt == CW'(1));
endmodule

// File: rtl/cmdseq_counter.sv
module cmdseq_counter #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          inc,
  output logic [CW-1:0] count
);
  always_ff @(posedge clk) begin
    if (rst || clr) count <= '0;
    else if (inc)   count <= count + 1'b1;
  end
endmodule

// File: rtl/cmdseq_engine.sv
module cmdseq_engine
  import cmdseq_pkg::*;
#(
  parameter int NUM_SEQ = 4,
  parameter int MEM_AW  = 8,
  parameter int GAP_W   = 8,
  parameter int CNT_W   = 16,
  localparam int SEL_W  = (NUM_SEQ > 1) ? $clog2(NUM_SEQ) : 1,
  localparam int LEN_W  = MEM_AW + 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      run_en,
  input  logic                      hold,
  input  logic [SEL_W-1:0]          seq_sel,
  input  logic [NUM_SEQ*MEM_AW-1:0] seq_base_all,
  input  logic [NUM_SEQ*LEN_W-1:0]  seq_len_all,
  input  logic [GAP_W-1:0]          wr_gap,
  output logic                      mem_rd_en,
  output logic [MEM_AW-1:0]         mem_rd_addr,
  input  logic [INSTR_W-1:0]        mem_rd_data,
  output logic                      reg_wr_en,
  output logic [REG_AW-1:0]         reg_wr_addr,
  output logic [INSTR_W-1:0]        reg_wr_data,
  input  logic                      cnt_clr,
  output logic [CNT_W-1:0]          cmd_count,
  output logic                      busy,
  output logic                      done
);
  seq_state_t        state;
  logic [MEM_AW-1:0] pc;
  logic [LEN_W-1:0]  rem;
  logic              fin;

  logic [MEM_AW-1:0] sel_base;
  logic [LEN_W-1:0]  sel_len;
  logic              go, exec_fire, wr_cmd, gap_zero;
  logic              tmr_load, tmr_run, tmr_expire;
  logic [TMR_W-1:0]  tmr_val;

  cmdseq_slot_pick #(
    .NUM_SEQ(NUM_SEQ), .BASE_W(MEM_AW), .LEN_W(LEN_W)
  ) u_pick (
    .sel(seq_sel), .base_all(seq_base_all), .len_all(seq_len_all),
    .base(sel_base), .len(sel_len)
  );

  assign go        = run_en && !hold;
  assign exec_fire = (state == ST_EXEC) && go;
  assign wr_cmd    = instr_is_write(mem_rd_data);
  assign gap_zero  = (wr_gap == '0);
  assign tmr_load  = exec_fire && !(wr_cmd && gap_zero);
  assign tmr_val   = wr_cmd ? TMR_W'(wr_gap) : instr_wait_len(mem_rd_data);
  assign tmr_run   = (state == ST_WAIT) && go;

  cmdseq_timer #(.CW(TMR_W)) u_timer (
    .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val),
    .run(tmr_run), .expire(tmr_expire)
  );

  cmdseq_counter #(.CW(CNT_W)) u_count (
    .clk(clk), .rst(rst), .clr(cnt_clr), .inc(exec_fire), .count(cmd_count)
  );

  assign mem_rd_en   = (state == ST_FETCH) && go;
  assign mem_rd_addr = pc;
  assign busy        = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      pc          <= '0;
      rem         <= '0;
      fin         <= 1'b0;
      reg_wr_en   <= 1'b0;
      reg_wr_addr <= '0;
      reg_wr_data <= '0;
      done        <= 1'b0;
    end else begin
      reg_wr_en <= 1'b0;
      done      <= 1'b0;
      if (!run_en) begin
        state <= ST_IDLE;
        fin   <= 1'b0;
      end else if (!hold) begin
        case (state)
          ST_IDLE: begin
            if (!fin) begin
              fin <= 1'b1;
              pc  <= sel_base;
              rem <= sel_len;
              if (sel_len == '0) done  <= 1'b1;
              else               state <= ST_FETCH;
            end
          end
          ST_FETCH: state <= ST_EXEC;
          ST_EXEC: begin
            pc  <= pc + 1'b1;
            rem <= rem - 1'b1;
            if (wr_cmd) begin
              reg_wr_en   <= 1'b1;
              reg_wr_addr <= instr_reg_addr(mem_rd_data);
              reg_wr_data <= instr_reg_data(mem_rd_data);
            end
            if (wr_cmd && gap_zero) begin
              if (rem == LEN_W'(1)) begin
                done  <= 1'b1;
                state <= ST_IDLE;
              end else begin
                state <= ST_FETCH;
              end
            end else begin
              state <= ST_WAIT;
            end
          end
          ST_WAIT: begin
            if (tmr_expire) begin
              if (rem == '0) begin
                done  <= 1'b1;
                state <= ST_IDLE;
              end else begin
                state <= ST_FETCH;
              end
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/cmdseq_engine_chk.sv
module cmdseq_engine_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             run_en,
  input logic             hold,
  input logic             cnt_clr,
  input logic             mem_rd_en,
  input logic             reg_wr_en,
  input logic             busy,
  input logic             done,
  input logic [CNT_W-1:0] cmd_count
);
  a_r2_read_when_busy: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en |-> busy);

  a_r2_single_read: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en |=> !mem_rd_en);

  a_r3_strobe_spacing: assert property (@(posedge clk) disable iff (rst)
    reg_wr_en |=> !reg_wr_en);

  a_r6_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r6_done_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  a_r8_hold_quiet: assert property (@(posedge clk) disable iff (rst)
    $past(hold) |-> (!reg_wr_en && !done));

  a_r8_hold_count: assert property (@(posedge clk) disable iff (rst)
    (hold && !cnt_clr) |=> $stable(cmd_count));

  a_r9_stop: assert property (@(posedge clk) disable iff (rst)
    !run_en |=> (!busy && !done));

  a_r10_count_step: assert property (@(posedge clk) disable iff (rst)
    !cnt_clr |=> ((cmd_count == $past(cmd_count)) ||
                  (cmd_count == $past(cmd_count) + 1'b1)));

  a_r10_clear: assert property (@(posedge clk) disable iff (rst)
    cnt_clr |=> (cmd_count == '0));
endmodule

bind cmdseq_engine cmdseq_engine_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .run_en(run_en), .hold(hold), .cnt_clr(cnt_clr),
  .mem_rd_en(mem_rd_en), .reg_wr_en(reg_wr_en), .busy(busy), .done(done),
  .cmd_count(cmd_count)
);

// File: tb/cmdseq_engine_bench.sv
`timescale 1ns/1ps
module cmdseq_engine_bench;
  localparam int NUM_SEQ = 4;
  localparam int MEM_AW  = 8;
  localparam int GAP_W   = 8;
  localparam int CNT_W   = 16;
  localparam int LEN_W   = MEM_AW + 1;
  localparam int SEL_W   = 2;
  localparam int SLOT    = 32;

  logic clk = 1'b0, rst = 1'b1, run_en = 1'b0, hold = 1'b0, cnt_clr = 1'b0;
  logic [SEL_W-1:0]          seq_sel = '0;
  logic [NUM_SEQ*MEM_AW-1:0] seq_base_all = '0;
  logic [NUM_SEQ*LEN_W-1:0]  seq_len_all = '0;
  logic [GAP_W-1:0]          wr_gap = '0;
  logic                      mem_rd_en;
  logic [MEM_AW-1:0]         mem_rd_addr;
  logic [31:0]               mem_rd_data;
  logic                      reg_wr_en;
  logic [8:0]                reg_wr_addr;
  logic [31:0]               reg_wr_data;
  logic [CNT_W-1:0]          cmd_count;
  logic                      busy, done;

  logic [31:0] mem [1<<MEM_AW];
  int total = 0, bad = 0;
  int prog_off [SLOT+1];

  always #5 clk = ~clk;

  always @(posedge clk) if (mem_rd_en) mem_rd_data <= mem[mem_rd_addr];

  cmdseq_engine #(.NUM_SEQ(NUM_SEQ), .MEM_AW(MEM_AW), .GAP_W(GAP_W), .CNT_W(CNT_W)) u_cmdseq_engine (
    .clk(clk), .rst(rst), .run_en(run_en), .hold(hold), .seq_sel(seq_sel),
    .seq_base_all(seq_base_all), .seq_len_all(seq_len_all), .wr_gap(wr_gap),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
    .cnt_clr(cnt_clr), .cmd_count(cmd_count), .busy(busy), .done(done)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_extra(input logic [31:0] w, input int gap);
    if (w[31]) return gap;
    if (w[29:0] == 30'd0) return 1;
    return int'(w[29:0]);
  endfunction

  task automatic load_prog(input int slot, input int n, input int mode);
    for (int i = 0; i < n; i++) begin
      logic [31:0] w;
      int kind;
      kind = (mode == 0) ? int'($urandom_range(0, 1)) : ((mode == 1) ? 1 : 0);
      if (kind == 1) w = {1'b1, 7'($urandom_range(0, 127)), 24'($urandom)};
      else           w = {1'b0, 1'($urandom_range(0, 1)), 30'($urandom_range(0, 4))};
      mem[slot*SLOT + i] = w;
    end
  endtask

  task automatic calc_off(input int slot, input int n, input int gap);
    prog_off[0] = 0;
    for (int i = 0; i < n; i++)
      prog_off[i+1] = prog_off[i] + 2 + exp_extra(mem[slot*SLOT + i], gap);
  endtask

  // hc/hk: hold from relative cycle hc for hk cycles; ab: drop run_en at ab
  task automatic run_case(input int slot, input int n, input int gap,
                          input int hc, input int hk, input int ab, input string tag);
    int base, horizon, e_fetch, e_addr, e_wr, e_done, e_busy, executed;
    base = slot * SLOT;
    e_fetch = 0; e_addr = 0; e_wr = 0; e_done = 0; e_busy = 0; executed = 0;
    calc_off(slot, n, gap);
    for (int k = 0; k < NUM_SEQ; k++)
      seq_len_all[k*LEN_W +: LEN_W] = (k == slot) ? LEN_W'(n) : LEN_W'(k + 11);
    seq_sel = SEL_W'(slot);
    wr_gap  = GAP_W'(gap);
    @(negedge clk); cnt_clr = 1'b1;
    @(negedge clk); cnt_clr = 1'b0;
    chk(cmd_count == '0, {"R10 clear ", tag}, cmd_count, 0);
    run_en = 1'b1;
    horizon = prog_off[n] + hk + 4;
    for (int rel = 0; rel <= horizon; rel++) begin
      int eff;
      bit quiet, gone, x_rd, x_wr, x_done, x_busy;
      logic [MEM_AW-1:0] x_ad;
      logic [8:0] x_wa;
      logic [31:0] x_wd;
      @(negedge clk);
      gone = (ab >= 0) && (rel > ab);
      quiet = 1'b0; eff = rel;
      if (hk > 0 && rel > hc) begin
        if (rel <= hc + hk) quiet = 1'b1;
        else eff = rel - hk;
      end
      x_rd = 1'b0; x_wr = 1'b0; x_ad = '0; x_wa = '0; x_wd = '0;
      if (!quiet && !gone) begin
        for (int i = 0; i < n; i++) begin
          if (eff == prog_off[i]) begin x_rd = 1'b1; x_ad = MEM_AW'(base + i); end
          if (mem[base+i][31] && eff == prog_off[i] + 2) begin
            x_wr = 1'b1;
            x_wa = {mem[base+i][30:24], 2'b00};
            x_wd = {8'h00, mem[base+i][23:0]};
          end
        end
      end
      x_done = !quiet && !gone && (eff == prog_off[n]);
      x_busy = !gone && (quiet || eff < prog_off[n]);
      if (rel == 0)
        chk((mem_rd_en === (n > 0)) && (n == 0 || mem_rd_addr == MEM_AW'(base)),
            {"R1 R11 first fetch ", tag}, mem_rd_addr, base);
      if (mem_rd_en !== x_rd) e_fetch++;
      else if (x_rd && mem_rd_addr !== x_ad) e_addr++;
      if (reg_wr_en !== x_wr || (x_wr && (reg_wr_addr !== x_wa || reg_wr_data !== x_wd))) e_wr++;
      if (done !== x_done) e_done++;
      if (busy !== x_busy) e_busy++;
      hold = (hk > 0 && rel >= hc && rel < hc + hk);
      if (ab >= 0 && rel == ab) run_en = 1'b0;
    end
    for (int i = 0; i < n; i++)
      if (ab < 0 || prog_off[i] + 1 < ab) executed++;
    chk(e_fetch == 0, {"R4 R5 fetch timing ", tag}, e_fetch, 0);
    chk(e_addr == 0,  {"R2 fetch address ", tag}, e_addr, 0);
    chk(e_wr == 0,    {"R3 write strobe ", tag}, e_wr, 0);
    chk(e_done == 0,  {"R6 done pulse ", tag}, e_done, 0);
    chk(e_busy == 0,  {"R1 busy ", tag}, e_busy, 0);
    chk(cmd_count == CNT_W'(executed), {"R10 count ", tag}, cmd_count, executed);
    run_en = 1'b0;
    hold   = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #(64'd2000000);
    total++; bad++;
    $display("FAIL watchdog R1..all actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int unsigned seed_v;
    int hc, hk;
    seed_v = $urandom(32'd2024);
    for (int a = 0; a < (1 << MEM_AW); a++) mem[a] = '0;
    for (int k = 0; k < NUM_SEQ; k++) seq_base_all[k*MEM_AW +: MEM_AW] = MEM_AW'(k * SLOT);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !done && !mem_rd_en && !reg_wr_en && cmd_count == '0,
        "R1 reset idle", {busy, done, mem_rd_en, reg_wr_en}, 0);

    load_prog(0, 6, 1); run_case(0, 6, 0, -1, 0, -1, "R4 writes gap0");
    load_prog(1, 5, 1); run_case(1, 5, 3, -1, 0, -1, "R4 writes gap3");
    load_prog(2, 4, 2);
    mem[2*SLOT + 1] = {2'b00, 30'd0};
    mem[2*SLOT + 2] = {2'b01, 30'd25};
    run_case(2, 4, 2, -1, 0, -1, "R5 timers zero and long");
    run_case(3, 0, 1, -1, 0, -1, "R7 empty sequence");
    load_prog(1, 6, 0);
    calc_off(1, 6, 2);
    run_case(1, 6, 2, prog_off[2] + 1, 5, -1, "R8 hold in execute");
    load_prog(3, 5, 2);
    calc_off(3, 5, 1);
    run_case(3, 5, 1, prog_off[1] + 2, 4, -1, "R8 hold in wait");
    load_prog(0, 8, 0);
    calc_off(0, 8, 1);
    run_case(0, 8, 1, -1, 0, prog_off[3] + 1, "R9 stop mid run");
    run_case(0, 8, 1, -1, 0, -1, "R9 restart from base");

    for (int r = 0; r < 24; r++) begin
      int slot, n, gap, idx;
      slot = int'($urandom_range(0, 3));
      n    = int'($urandom_range(1, 12));
      gap  = int'($urandom_range(0, 5));
      load_prog(slot, n, 0);
      calc_off(slot, n, gap);
      hc = -1; hk = 0;
      if ($urandom_range(0, 1) == 1) begin
        idx = int'($urandom_range(0, n - 1));
        hc  = prog_off[idx] + 1 + int'($urandom_range(0, prog_off[idx+1] - prog_off[idx] - 2));
        hk  = int'($urandom_range(1, 6));
      end
      run_case(slot, n, gap, hc, hk, -1, "R11 R8 random run");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule